// File: doc/BRIEF.md
# Capability Tag Memory Controller

This block keeps one validity bit for every aligned, capability-sized word of data memory. The core sends one request at a time. A request is a plain data load, a plain data store, a capability load or a capability store. Each request carries a byte address, a full word of write data, a byte mask and an incoming tag bit. Data traffic goes unchanged to a memory-side port. The validity bits sit in a separate tag store inside the block, which stands in for a reserved tag partition of memory. The tag index is the word number, that is the byte address divided by the capability size in bytes.

The tag of a word changes in only two ways. A capability store writes the tag that arrives with it. A plain store that writes any byte of a word clears that word's tag, so a word that has been overwritten can never pass as a capability. A capability load returns the stored tag with the data. A plain load returns data only and does not touch the tag. The capability width is a parameter: 128 bits gives one tag bit per 16 bytes, and 256 bits gives one tag bit per 32 bytes. The data bus is one capability word wide.

Top module: `captag_ctrl`

## Requirements
- R1: After reset every tag reads as zero, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low.
- R2: A capability store (`req_kind` = 3) at an aligned address writes `req_tag` into the tag of word `req_addr >> log2(CAP_BITS/8)`. It writes the whole data word to memory with `mem_wmask` all ones, whatever `req_wmask` holds.
- R3: A capability load (`req_kind` = 2) at an aligned address returns the memory data on `rsp_rdata` and the stored tag of that word on `rsp_tag`.
- R4: A plain store (`req_kind` = 1) with at least one `req_wmask` bit set clears the tag of the word it addresses. A plain store with an all-zero mask leaves the tag as it was.
- R5: A plain load (`req_kind` = 0) returns the memory data with `rsp_tag` = 0 and leaves the stored tag unchanged. Every response except a capability load carries `rsp_tag` = 0.
- R6: A capability access whose address has any of its low log2(CAP_BITS/8) bits set is answered with `rsp_err` = 1 and `rsp_tag` = 0. It makes no memory request and changes no tag.
- R7: A tag update changes only the addressed word. Tags of neighbouring words keep their values.
- R8: `req_ready` is high only while no request is outstanding. `mem_req_*` stay stable while `mem_req_valid` waits for `mem_req_ready`. The response stays stable while `rsp_valid` waits for `rsp_ready`.
- R9: A request that reaches memory is answered only after `mem_rsp_valid` has been seen. For stores this means the memory write and the tag update have both finished before the response.
- R10: For plain accesses, `mem_addr`, `mem_wdata` and `mem_wmask` carry the core's address, data and byte mask unchanged, and `mem_we` is high only for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller accepts a request |
| req_kind | input | 2 | 0 plain load, 1 plain store, 2 capability load, 3 capability store |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | CAP_BITS | Store data |
| req_wmask | input | CAP_BITS/8 | Store byte enables |
| req_tag | input | 1 | Tag bit carried by a capability store |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Core takes the response |
| rsp_rdata | output | CAP_BITS | Load data (zero for stores and errors) |
| rsp_tag | output | 1 | Tag returned by a capability load |
| rsp_err | output | 1 | Misaligned capability access |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | CAP_BITS | Memory write data |
| mem_wmask | output | CAP_BITS/8 | Memory byte enables (zero for loads) |
| mem_rsp_valid | input | 1 | Memory completion, for reads and writes alike |
| mem_rsp_rdata | input | CAP_BITS | Memory read data |

## Verification
The assertions assume that memory raises `mem_rsp_valid` for exactly one cycle per accepted request, and only while a request is outstanding. They also assume that `req_kind` is stable during the handshake cycle. The bench memory model accepts at most one request at a time and answers one cycle after acceptance, with a stall control that holds `mem_req_ready` low. Core requests are driven away from the clock edge and held until accepted, so the assumed input behaviour always holds.

// File: rtl/captag_pkg.sv
// Shared types for the capability tag controller.
// Assumes: the access kind encoding is fixed, and the core and the bench rely on it.
package captag_pkg;

    typedef enum logic [1:0] {
        ACC_DLOAD  = 2'd0,
        ACC_DSTORE = 2'd1,
        ACC_CLOAD  = 2'd2,
        ACC_CSTORE = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/captag_addr_map.sv
// Maps a byte address to a tag index and flags misaligned capability accesses.
// Assumes: the capability size is a power of two number of bytes.
module captag_addr_map
    import captag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    output logic [IDX_W-1:0]  tag_idx,
    output logic              misaligned
);

    logic is_cap;

    // Capability kinds have the upper encoding bit set.
    assign is_cap = (acc_kind_e'(kind) == ACC_CLOAD) || (acc_kind_e'(kind) == ACC_CSTORE);

    // Word number selects the tag bit; the offset within the word must be zero for capabilities.
    always_comb begin
        tag_idx    = addr[ADDR_W-1:OFF_W];
        misaligned = is_cap && (addr[OFF_W-1:0] != '0);
    end

endmodule

// File: rtl/captag_tag_ram.sv
// Tag store: one bit per capability word, cleared on reset, one write port and one read port.
// Assumes: the read is combinational and a write takes effect at the next edge.
module captag_tag_ram #(
    parameter int IDX_W = 8,
    parameter int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_tag
);

    logic [DEPTH-1:0] bits_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Each entry is reset to invalid and written only when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_q[g] <= 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                bits_q[g] <= wr_tag;
        end
    end

    // Read port returns the addressed validity bit.
    assign rd_tag = bits_q[rd_idx];

endmodule

// File: rtl/captag_seq.sv
// Request sequencer: accepts one core request, forwards it to memory, updates or reads
// the tag on memory completion, and holds the response until the core takes it.
// Assumes: memory gives one mem_rsp_valid pulse per accepted request.
module captag_seq
    import captag_pkg::*;
#(
    parameter int CAP_BITS  = 128,
    parameter int ADDR_W    = 12,
    parameter int IDX_W     = 8,
    parameter int CAP_BYTES = CAP_BITS / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CAP_BITS-1:0]  req_wdata,
    input  logic [CAP_BYTES-1:0] req_wmask,
    input  logic                 req_tag,
    input  logic [IDX_W-1:0]     map_idx,
    input  logic                 map_misaligned,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [CAP_BITS-1:0]  rsp_rdata,
    output logic                 rsp_tag,
    output logic                 rsp_err,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [CAP_BITS-1:0]  mem_wdata,
    output logic [CAP_BYTES-1:0] mem_wmask,
    input  logic                 mem_rsp_valid,
    input  logic [CAP_BITS-1:0]  mem_rsp_rdata,
    output logic [IDX_W-1:0]     tag_rd_idx,
    input  logic                 tag_rd,
    output logic                 tag_we,
    output logic [IDX_W-1:0]     tag_wr_idx,
    output logic                 tag_wr
);

    seq_state_e             st_q;
    acc_kind_e              kind_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [CAP_BITS-1:0]    wdata_q;
    logic [CAP_BYTES-1:0]   mask_q;
    logic                   tin_q;
    logic [IDX_W-1:0]       idx_q;
    logic [CAP_BITS-1:0]    rdata_q;
    logic                   rtag_q;
    logic                   err_q;
    logic                   is_store;
    logic                   done;

    // A store is either plain or capability.
    assign is_store = (kind_q == ACC_DSTORE) || (kind_q == ACC_CSTORE);
    // Memory completion for the outstanding request.
    assign done     = (st_q == ST_WAIT) && mem_rsp_valid;

    // State and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            kind_q  <= ACC_DLOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            tin_q   <= 1'b0;
            idx_q   <= '0;
            rdata_q <= '0;
            rtag_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        kind_q  <= acc_kind_e'(req_kind);
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        mask_q  <= (acc_kind_e'(req_kind) == ACC_CSTORE) ? '1 : req_wmask;
                        tin_q   <= req_tag;
                        idx_q   <= map_idx;
                        rdata_q <= '0;
                        rtag_q  <= 1'b0;
                        err_q   <= map_misaligned;
                        st_q    <= map_misaligned ? ST_RESP : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready)
                        st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rdata_q <= is_store ? '0 : mem_rsp_rdata;
                        rtag_q  <= (kind_q == ACC_CLOAD) ? tag_rd : 1'b0;
                        st_q    <= ST_RESP;
                    end
                end
                default: begin
                    if (rsp_ready)
                        st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Handshake and memory-side drives.
    always_comb begin
        req_ready     = (st_q == ST_IDLE);
        mem_req_valid = (st_q == ST_ISSUE);
        mem_we        = is_store;
        mem_addr      = addr_q;
        mem_wdata     = wdata_q;
        mem_wmask     = is_store ? mask_q : '0;
        rsp_valid     = (st_q == ST_RESP);
        rsp_rdata     = rdata_q;
        rsp_tag       = rtag_q;
        rsp_err       = err_q;
    end

    // Tag update on store completion: capability stores write, touching plain stores clear.
    always_comb begin
        tag_rd_idx = idx_q;
        tag_wr_idx = idx_q;
        tag_we     = done && ((kind_q == ACC_CSTORE) || ((kind_q == ACC_DSTORE) && (|mask_q)));
        tag_wr     = (kind_q == ACC_CSTORE) ? tin_q : 1'b0;
    end

endmodule

// File: rtl/captag_ctrl.sv
// Top of the capability tag controller: address mapping, tag store and sequencer.
// Assumes: one outstanding request and a data bus one capability word wide.
module captag_ctrl #(
    parameter int CAP_BITS = 128,
    parameter int ADDR_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_kind,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [CAP_BITS-1:0]     req_wdata,
    input  logic [CAP_BITS/8-1:0]   req_wmask,
    input  logic                    req_tag,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [CAP_BITS-1:0]     rsp_rdata,
    output logic                    rsp_tag,
    output logic                    rsp_err,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [CAP_BITS-1:0]     mem_wdata,
    output logic [CAP_BITS/8-1:0]   mem_wmask,
    input  logic                    mem_rsp_valid,
    input  logic [CAP_BITS-1:0]     mem_rsp_rdata
);

    localparam int CAP_BYTES = CAP_BITS / 8;
    localparam int OFF_W     = $clog2(CAP_BYTES);
    localparam int IDX_W     = ADDR_W - OFF_W;
    localparam int DEPTH     = 1 << IDX_W;

    logic [IDX_W-1:0] map_idx;
    logic             map_misaligned;
    logic [IDX_W-1:0] tag_rd_idx;
    logic             tag_rd;
    logic             tag_we;
    logic [IDX_W-1:0] tag_wr_idx;
    logic             tag_wr;

    captag_addr_map #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W),
        .IDX_W (IDX_W)
    ) map_i (
        .addr      (req_addr),
        .kind      (req_kind),
        .tag_idx   (map_idx),
        .misaligned(map_misaligned)
    );

    captag_tag_ram #(
        .IDX_W(IDX_W),
        .DEPTH(DEPTH)
    ) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(tag_rd_idx),
        .rd_tag(tag_rd),
        .wr_en (tag_we),
        .wr_idx(tag_wr_idx),
        .wr_tag(tag_wr)
    );

    captag_seq #(
        .CAP_BITS (CAP_BITS),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .CAP_BYTES(CAP_BYTES)
    ) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_kind      (req_kind),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .req_wmask     (req_wmask),
        .req_tag       (req_tag),
        .map_idx       (map_idx),
        .map_misaligned(map_misaligned),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_rdata     (rsp_rdata),
        .rsp_tag       (rsp_tag),
        .rsp_err       (rsp_err),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_wmask     (mem_wmask),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .tag_rd_idx    (tag_rd_idx),
        .tag_rd        (tag_rd),
        .tag_we        (tag_we),
        .tag_wr_idx    (tag_wr_idx),
        .tag_wr        (tag_wr)
    );

endmodule

// File: rtl/captag_chk.sv
// Protocol and tag-rule checker bound to captag_ctrl.
// Assumes: memory answers once per accepted request, and req_kind is stable at the handshake.
module captag_chk #(
    parameter int CAP_BITS = 128,
    parameter int ADDR_W   = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [1:0]            req_kind,
    input logic                  rsp_valid,
    input logic                  rsp_ready,
    input logic [CAP_BITS-1:0]   rsp_rdata,
    input logic                  rsp_tag,
    input logic                  rsp_err,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic                  mem_we,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [CAP_BITS/8-1:0] mem_wmask,
    input logic                  mem_rsp_valid
);

    logic [1:0] kind_seen;

    // Remember the kind of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kind_seen <= 2'd0;
        else if (req_valid && req_ready)
            kind_seen <= req_kind;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (req_ready && !rsp_valid && !mem_req_valid));

    p_full_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && kind_seen == 2'd3) |-> (mem_we && (&mem_wmask)));

    p_tag_only_cap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind_seen != 2'd2) |-> !rsp_tag);

    p_err_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_err) |-> (!$past(mem_req_valid) && !rsp_tag));

    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || mem_req_valid)));

    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wmask)));

    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_rdata) && $stable(rsp_tag) && $stable(rsp_err)));

    p_ack_after_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && !rsp_err) |-> $past(mem_rsp_valid));

endmodule

bind captag_ctrl captag_chk #(
    .CAP_BITS(CAP_BITS),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_rdata    (rsp_rdata),
    .rsp_tag      (rsp_tag),
    .rsp_err      (rsp_err),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wmask    (mem_wmask),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/captag_ctrl_tb_top.sv
// Bench for captag_ctrl: a table of tag operations, then directed tests for data,
// back-pressure, memory stall and reset.
module captag_ctrl_tb_top;

    localparam int CAP_BITS = 128;
    localparam int ADDR_W   = 12;
    localparam int NB       = CAP_BITS / 8;
    localparam int WORDS    = 1 << (ADDR_W - 4);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [1:0]          req_kind = 2'd0;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic [CAP_BITS-1:0] req_wdata = '0;
    logic [NB-1:0]       req_wmask = '0;
    logic                req_tag = 1'b0;
    logic                rsp_valid;
    logic                rsp_ready = 1'b1;
    logic [CAP_BITS-1:0] rsp_rdata;
    logic                rsp_tag;
    logic                rsp_err;
    logic                mem_req_valid;
    logic                mem_req_ready;
    logic                mem_we;
    logic [ADDR_W-1:0]   mem_addr;
    logic [CAP_BITS-1:0] mem_wdata;
    logic [NB-1:0]       mem_wmask;
    logic                mem_rsp_valid;
    logic [CAP_BITS-1:0] mem_rsp_rdata;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  n_mem_acc = 0;
    int  cycles = 0;
    logic stall = 1'b0;

    always #4 clk = ~clk;

    captag_ctrl #(.CAP_BITS(CAP_BITS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .rsp_tag(rsp_tag), .rsp_err(rsp_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // Memory model: one request at a time, answer one cycle after acceptance.
    logic [CAP_BITS-1:0] mem_arr [WORDS];
    logic                pend = 1'b0;
    assign mem_req_ready = !stall && !pend;

    initial begin
        for (int i = 0; i < WORDS; i++) mem_arr[i] = '0;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
    end

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            pend          <= 1'b0;
            mem_rsp_valid <= 1'b1;
        end else if (mem_req_valid && mem_req_ready) begin
            n_mem_acc <= n_mem_acc + 1;
            pend      <= 1'b1;
            mem_rsp_rdata <= mem_arr[mem_addr[ADDR_W-1:4]];
            if (mem_we)
                for (int b = 0; b < NB; b++)
                    if (mem_wmask[b]) mem_arr[mem_addr[ADDR_W-1:4]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [CAP_BITS-1:0] act,
                         input logic [CAP_BITS-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Drive one request and wait until it is accepted.
    task automatic send(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                        input logic [CAP_BITS-1:0] d, input logic [NB-1:0] m, input logic t);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d; req_wmask = m; req_tag = t;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Wait for the response; fields are sampled at a falling edge.
    task automatic get_rsp(output logic [CAP_BITS-1:0] d, output logic t, output logic e);
        while (!rsp_valid) @(negedge clk);
        d = rsp_rdata; t = rsp_tag; e = rsp_err;
        @(negedge clk);
    endtask

    task automatic xact(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                        input logic [CAP_BITS-1:0] d, input logic [NB-1:0] m, input logic t,
                        output logic [CAP_BITS-1:0] rd, output logic rt, output logic re);
        send(k, a, d, m, t);
        get_rsp(rd, rt, re);
    endtask

    // Vector fields: kind[32:31] addr[30:19] mask[18:3] tag_in[2] exp_tag[1] exp_err[0]
    localparam int NV = 19;
    localparam logic [32:0] VEC [NV] = '{
        {2'd2, 12'h100, 16'h0000, 1'b0, 1'b0, 1'b0},  // R1 fresh tag zero
        {2'd3, 12'h100, 16'h0000, 1'b1, 1'b0, 1'b0},  // R2 cap store tag 1
        {2'd2, 12'h100, 16'h0000, 1'b0, 1'b1, 1'b0},  // R3 load tag back
        {2'd0, 12'h104, 16'h0000, 1'b0, 1'b0, 1'b0},  // R5 plain load no tag
        {2'd2, 12'h100, 16'h0000, 1'b0, 1'b1, 1'b0},  // R5 tag kept
        {2'd1, 12'h10F, 16'h8000, 1'b1, 1'b0, 1'b0},  // R4 one byte store
        {2'd2, 12'h100, 16'h0000, 1'b0, 1'b0, 1'b0},  // R4 cleared
        {2'd3, 12'h200, 16'h0000, 1'b1, 1'b0, 1'b0},  // R2
        {2'd1, 12'h200, 16'h0000, 1'b0, 1'b0, 1'b0},  // R4 empty mask
        {2'd2, 12'h200, 16'h0000, 1'b0, 1'b1, 1'b0},  // R4 kept
        {2'd3, 12'h208, 16'hFFFF, 1'b0, 1'b0, 1'b1},  // R6 misaligned store
        {2'd2, 12'h208, 16'h0000, 1'b0, 1'b0, 1'b1},  // R6 misaligned load
        {2'd2, 12'h200, 16'h0000, 1'b0, 1'b1, 1'b0},  // R6 tag untouched
        {2'd3, 12'h210, 16'h0000, 1'b1, 1'b0, 1'b0},  // R7 neighbour set
        {2'd1, 12'h200, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R7 clear word 0x200
        {2'd2, 12'h210, 16'h0000, 1'b0, 1'b1, 1'b0},  // R7 neighbour intact
        {2'd3, 12'hFF0, 16'h0000, 1'b1, 1'b0, 1'b0},  // R2 last word
        {2'd2, 12'hFF0, 16'h0000, 1'b0, 1'b1, 1'b0},  // R3 last word
        {2'd3, 12'h220, 16'h0000, 1'b0, 1'b0, 1'b0}   // R2 store tag zero
    };

    initial begin
        logic [CAP_BITS-1:0] rd;
        logic rt, re;
        int acc0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
              {rsp_valid, mem_req_valid, req_ready}, 3'b001);

        for (int i = 0; i < NV; i++) begin
            acc0 = n_mem_acc;
            xact(VEC[i][32:31], VEC[i][30:19], {4{32'h5A00_0000 | i}}, VEC[i][18:3],
                 VEC[i][2], rd, rt, re);
            check(rt == VEC[i][1], $sformatf("R3 vector %0d tag", i), rt, VEC[i][1]);
            check(re == VEC[i][0], $sformatf("R6 vector %0d err", i), re, VEC[i][0]);
            if (VEC[i][0])
                check(n_mem_acc == acc0, "R6 no memory access", n_mem_acc - acc0, 0);
        end

        // R10 plain store pass-through, seen while memory stalls.
        stall = 1'b1;
        send(2'd1, 12'h300, {4{32'h1111_2222}}, 16'hFFFF, 1'b0);
        check(mem_req_valid && mem_we && mem_addr == 12'h300 && mem_wmask == 16'hFFFF,
              "R10 store drive", {mem_we, mem_addr, mem_wmask}, {1'b1, 12'h300, 16'hFFFF});
        stall = 1'b0;
        get_rsp(rd, rt, re);
        stall = 1'b1;
        send(2'd1, 12'h300, {4{32'hAAAA_BBBB}}, 16'h000F, 1'b1);
        check(mem_wmask == 16'h000F && mem_wdata == {4{32'hAAAA_BBBB}}, "R10 partial mask",
              mem_wmask, 16'h000F);
        repeat (3) @(negedge clk);
        check(!rsp_valid && mem_req_valid, "R9 no ack while memory stalls",
              {rsp_valid, mem_req_valid}, 2'b01);
        stall = 1'b0;
        get_rsp(rd, rt, re);
        xact(2'd0, 12'h300, '0, '0, 1'b0, rd, rt, re);
        check(rd == {32'h1111_2222, 32'h1111_2222, 32'h1111_2222, 32'hAAAA_BBBB},
              "R10 load data", rd, {32'h1111_2222, 32'h1111_2222, 32'h1111_2222, 32'hAAAA_BBBB});
        check(rt == 1'b0, "R5 plain load tag", rt, 0);

        // R2 cap store ignores a partial mask; R3 data returned.
        stall = 1'b1;
        send(2'd3, 12'h310, {4{32'hC0DE_0001}}, 16'h0001, 1'b1);
        check(&mem_wmask, "R2 full mask on capability store", mem_wmask, 16'hFFFF);
        stall = 1'b0;
        get_rsp(rd, rt, re);
        xact(2'd2, 12'h310, '0, '0, 1'b0, rd, rt, re);
        check(rd == {4{32'hC0DE_0001}} && rt, "R3 capability load data and tag",
              {rt, rd}, {1'b1, {4{32'hC0DE_0001}}});

        // R8 response held under back-pressure.
        rsp_ready = 1'b0;
        send(2'd2, 12'h310, '0, '0, 1'b0);
        while (!rsp_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        check(rsp_valid && !req_ready && rsp_tag, "R8 response held",
              {rsp_valid, req_ready, rsp_tag}, 3'b101);
        rsp_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(req_ready && !rsp_valid, "R8 idle after take", {req_ready, rsp_valid}, 2'b10);

        // R1 reset clears every tag.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        xact(2'd2, 12'h310, '0, '0, 1'b0, rd, rt, re);
        check(rt == 1'b0, "R1 tag zero after reset", rt, 0);
        xact(2'd2, 12'h210, '0, '0, 1'b0, rd, rt, re);
        check(rt == 1'b0, "R1 neighbour tag zero after reset", rt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule